// File: doc/BRIEF.md
# Flash Busy-Status Read Path

This block sits on the read side of a byte-wide parallel flash model and decides what the data bus carries while an internally timed program or erase operation runs. The command decoder supplies a busy flag, an erase-versus-program flag, and the address and data of the byte most recently loaded for programming. The array supplies the stored byte for the current read address. While the operation runs, the block overlays two progress indicators on the returned byte. Once the operation ends, the block returns the stored byte unchanged.

The first indicator is a polling bit on data bit 7. A read of the loaded address during a byte program returns the complement of the loaded bit 7. During a chip erase, bit 7 reads as 0, which is the complement of the erased value 1. The second indicator is on data bit 6. It changes value once for every new read access while the operation runs, at any address. A read access opens when chip enable and output enable are both active, so software can frame successive reads with either enable or with both.

All outputs are registered. The byte returned for a read appears one clock after the strobe and address are sampled.

Top module: `flash_status_readout`

## Requirements
- R1: While busy with a byte program (busy=1, erase_op=0), a read whose address equals ld_addr returns the complement of ld_data bit 7 on rd_data bit 7.
- R2: While busy with a chip erase (busy=1, erase_op=1), rd_data bit 7 reads 0 at every address.
- R3: While busy, rd_data bit 6 takes the opposite value from the previous read each time a new read access opens. A new access is the first cycle in which chip_en and out_en are both 1 after a cycle in which either was 0, so toggling either enable counts.
- R4: While busy, bit 6 holds its value for the whole length of one read access and between accesses. A long strobe therefore changes it once at most.
- R5: When busy is 0, every bit of rd_data equals arr_data, including bits 7 and 6.
- R6: bus_oe is 1 one clock after a cycle with chip_en=1 and out_en=1, and 0 one clock after any other cycle. When bus_oe is 0 the pins are treated as high impedance.
- R7: While busy, bits other than 7 and 6 carry arr_data. During a program, bit 7 also carries arr_data at addresses other than ld_addr.
- R8: A synchronous active-high reset clears rd_data to 0 and bus_oe to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| rd_addr | input | AW (19) | Read address |
| arr_data | input | DW (8) | Array content at rd_addr |
| busy | input | 1 | Internal operation in progress |
| erase_op | input | 1 | Running operation is a chip erase (1) or a byte program (0) |
| ld_addr | input | AW (19) | Address of the last byte loaded for programming |
| ld_data | input | DW (8) | Data of the last byte loaded for programming |
| rd_data | output | DW (8) | Registered read bus value |
| bus_oe | output | 1 | Registered bus drive enable; 0 means high impedance |

## Verification
The embedded properties check four rules on every cycle:
- the inverted polling bit on a hit at the loaded address during a program;
- the forced zero on bit 7 during an erase;
- true data returned when idle and the bus drive following the strobe;
- the internal toggle flipping exactly once per new access while busy and holding otherwise.

Whether bit 6 alternates when observed across separate reads at the pins, whether access framing by chip enable alone or by output enable alone both count, and whether a long strobe counts once, are shown only by the bench's scenarios. The bench tracks the observed bit 6 across reads and never assumes its starting value.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_kind_e;
endpackage

// File: rtl/flash_strobe_edge.sv
module flash_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic chip_en,
  input  logic out_en,
  output logic strobe,
  output logic rise
);
  logic strobe_q;

  assign strobe = chip_en & out_en;
  assign rise   = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  // A rise cannot occur on two consecutive cycles
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);  // R4
endmodule

// File: rtl/flash_toggle_gen.sv
module flash_toggle_gen (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rise,
  output logic tog_q,
  output logic tog_nx
);
  assign tog_nx = (busy && rise) ? ~tog_q : tog_q;

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_nx;
  end

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
    (busy && rise) |=> (tog_q != $past(tog_q)));  // R3
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(busy && rise) |=> $stable(tog_q));  // R4
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_stat_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  op_kind_e          kind,
  input  logic [AW-1:0]     rd_addr,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DW-1:0]     arr_data,
  input  logic [DW-1:0]     ld_data,
  input  logic              tog,
  output logic [DW-1:0]     data_out
);
  logic addr_hit;
  assign addr_hit = (rd_addr == ld_addr);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign data_out[b] = (kind == OP_ERASE) ? 1'b0 :
                           (kind == OP_PROG && addr_hit) ? ~ld_data[b] :
                           arr_data[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign data_out[b] = (kind == OP_IDLE) ? arr_data[b] : tog;
    end else begin : g_pass
      assign data_out[b] = arr_data[b];
    end
  end
endmodule

// File: rtl/flash_status_readout.sv
module flash_status_readout
  import flash_stat_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_en,
  input  logic          out_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          busy,
  input  logic          erase_op,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] rd_data,
  output logic          bus_oe
);
  logic          strobe, rise, tog_q, tog_nx;
  logic [DW-1:0] mux_data;
  op_kind_e      kind;

  assign kind = !busy ? OP_IDLE : (erase_op ? OP_ERASE : OP_PROG);

  flash_strobe_edge i_edge (
    .clk(clk), .rst(rst), .chip_en(chip_en), .out_en(out_en),
    .strobe(strobe), .rise(rise)
  );

  flash_toggle_gen i_tog (
    .clk(clk), .rst(rst), .busy(busy), .rise(rise),
    .tog_q(tog_q), .tog_nx(tog_nx)
  );

  flash_status_mux #(.AW(AW), .DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) i_mux (
    .kind(kind), .rd_addr(rd_addr), .ld_addr(ld_addr), .arr_data(arr_data),
    .ld_data(ld_data), .tog(tog_nx), .data_out(mux_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      bus_oe  <= 1'b0;
    end else begin
      rd_data <= mux_data;
      bus_oe  <= strobe;
    end
  end

  AST_POLL_INV: assert property (@(posedge clk) disable iff (rst)
    (busy && !erase_op && chip_en && out_en && rd_addr == ld_addr)
      |=> (rd_data[POLL_BIT] != $past(ld_data[POLL_BIT])));  // R1
  AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busy && erase_op) |=> (rd_data[POLL_BIT] == 1'b0));  // R2
  AST_IDLE_TRUE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (rd_data == $past(arr_data)));  // R5
  AST_BUS_HIZ: assert property (@(posedge clk) disable iff (rst)
    !(chip_en && out_en) |=> !bus_oe);  // R6
  AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (chip_en && out_en) |=> bus_oe);  // R6
endmodule

// File: tb/test_flash_status_readout.sv
module test_flash_status_readout;
  localparam int AW = 19;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chip_en = 1'b0, out_en = 1'b0, busy = 1'b0, erase_op = 1'b0;
  logic [AW-1:0] rd_addr = '0, ld_addr = '0;
  logic [DW-1:0] arr_data = '0, ld_data = '0;
  logic [DW-1:0] rd_data;
  logic          bus_oe;

  int n_chk = 0, n_bad = 0;
  logic pst = 1'b0, tog_known = 1'b0, last_b6 = 1'b0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  flash_status_readout i_flash_status_readout (
    .clk(clk), .rst(rst), .chip_en(chip_en), .out_en(out_en), .rd_addr(rd_addr),
    .arr_data(arr_data), .busy(busy), .erase_op(erase_op), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_data(rd_data), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected value of bit 7 and the pass-through bits
  function automatic logic [DW-1:0] exp_fixed(input logic bz, input logic er,
                                              input logic [AW-1:0] ra,
                                              input logic [DW-1:0] ad);
    logic [DW-1:0] e = ad;
    if (bz && er) e[7] = 1'b0;
    else if (bz && ra == ld_addr) e[7] = ~ld_data[7];
    return e;
  endfunction

  // One clock: drive at negedge, check after the next posedge
  task automatic cyc(input logic ce, input logic oe, input logic bz, input logic er,
                     input logic [AW-1:0] ra);
    logic st, rs;
    logic [DW-1:0] ad, e;
    chip_en = ce; out_en = oe; busy = bz; erase_op = er; rd_addr = ra;
    ad = DW'($urandom); arr_data = ad;
    st = ce & oe; rs = st & ~pst;
    e = exp_fixed(bz, er, ra, ad);
    @(posedge clk); #1;
    chk(bus_oe == st, "R6", int'(bus_oe), int'(st));
    if (st) begin
      if (!bz) chk(rd_data == ad, "R5", rd_data, ad);
      else begin
        chk(rd_data[5:0] == ad[5:0], "R7", rd_data[5:0], ad[5:0]);
        if (er) chk(rd_data[7] == 1'b0, "R2", rd_data[7], 0);
        else if (ra == ld_addr) chk(rd_data[7] == e[7], "R1", rd_data[7], e[7]);
        else chk(rd_data[7] == ad[7], "R7", rd_data[7], ad[7]);
        if (tog_known) begin
          if (rs) chk(rd_data[6] == ~last_b6, "R3", rd_data[6], ~last_b6);
          else    chk(rd_data[6] == last_b6, "R4", rd_data[6], last_b6);
        end
        last_b6 = rd_data[6];
        tog_known = 1'b1;
      end
    end
    if (!bz) tog_known = 1'b0;
    pst = st;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_data == '0, "R8", rd_data, 0);
    chk(bus_oe == 1'b0, "R8", bus_oe, 0);
    rst = 1'b0;
    // idle reads return true data
    for (int i = 0; i < 20; i++) cyc(1'b1, i[0], 1'b0, 1'b0, AW'($urandom));
    // program: poll the loaded address, framed by out_en
    ld_addr = AW'(19'h2A5C3); ld_data = 8'h5A;
    cyc(1'b1, 1'b1, 1'b1, 1'b0, ld_addr);
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b0, ld_addr);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, ld_addr);
    end
    // framed by chip_en
    for (int i = 0; i < 10; i++) begin
      cyc(1'b0, 1'b1, 1'b1, 1'b0, ld_addr);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, AW'($urandom));
    end
    // long strobe counts once
    cyc(1'b0, 1'b0, 1'b1, 1'b0, ld_addr);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, ld_addr);
    // loaded bit 7 = 1
    ld_data = 8'hC3;
    for (int i = 0; i < 6; i++) cyc(i[0], 1'b1, 1'b1, 1'b0, ld_addr);
    // operation ends
    for (int i = 0; i < 6; i++) cyc(1'b1, i[0], 1'b0, 1'b0, ld_addr);
    // chip erase
    for (int i = 0; i < 16; i++) cyc(1'b1, i[0], 1'b1, 1'b1, AW'($urandom));
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, AW'($urandom));
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic bz, er;
      logic [AW-1:0] ra;
      if (i % 100 == 0) begin
        ld_addr = AW'($urandom); ld_data = DW'($urandom);
      end
      bz = ((i / 50) % 3) != 0;
      er = ((i / 150) % 2) == 1;
      ra = ($urandom % 2) ? ld_addr : AW'($urandom);
      cyc(1'($urandom), 1'($urandom), bz, er, ra);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule